// File: doc/BRIEF.md
# Local Interrupt Controller Register Bank

This block is the register-access front end of a local interrupt controller. A single-cycle read/write port presents a byte offset, a write flag and write data. The offset is aligned down to a multiple of eight by clearing bits 2:0. It then selects one register slot on a 16-byte grid. Each slot applies its own write rule. Some fields are masked, some bits are forced to one, and status bits stay read-only inside otherwise writable words. Read data is registered and appears on `rd_data` one clock after the access is sampled.

The error-status word is controlled by a two-state machine with states `ERR_IDLE` and `ERR_ARMED`. It has four transitions:
- `ERR_IDLE -> ERR_ARMED` on a write to the error slot. The stored value is left as it is.
- `ERR_ARMED -> ERR_IDLE` on a write to the error slot. The stored value is cleared.
- `any -> ERR_IDLE` on a read of the error slot. The stored value is left as it is.
- Any other cycle holds the current state.

Hardware sources can set error bits at any time through a sticky input. A write to the end-of-interrupt slot stores nothing and raises a one-cycle strobe. Any access to an offset that has no register returns zero, changes nothing and raises a one-cycle error response.

Top module: `lic_regbank`

## Requirements
- R1: The slot is chosen by the offset with bits 2:0 cleared. For example, 0x024 selects the ID slot at 0x020. An aligned offset that is not one of 0x020, 0x030, 0x080, 0x0B0, 0x0D0, 0x0E0, 0x0F0, 0x280 or 0x320/0x330/0x340/0x350/0x360/0x370 (for example 0x028 or 0x328) is unmapped.
- R2: A write to the ID slot (0x020) keeps only bits 7:0. The same rule applies to the task-priority slot (0x080). All other bits read back as zero.
- R3: The version slot (0x030) always reads `VERSION_VAL`, which defaults to 0x0005_0014. Writes to it are dropped.
- R4: The logical-destination slot (0x0D0) keeps only bits 31:24 of a write. The destination-format slot (0x0E0) stores the write value with bits 27:0 forced to one.
- R5: In each of the six vector-table entries (0x320 + 16*k), bits 12 and 14 keep their previous value on a write. Every other bit takes the written value.
- R6: A write to the spurious-vector slot (0x0F0) stores the full word. It also sets output `sw_enable` to bit 8 of the written value.
- R7: Error-status writes follow the two-step handshake. The first write arms the state machine and leaves the value unchanged. The second write disarms it and zeroes the value.
- R8: A read of the error-status slot (0x280) disarms the handshake. A write after a read therefore only re-arms and does not clear.
- R9: Each set bit of `hw_err_set` is ORed into error-status bits `ERR_W-1:0` on the next edge. It stays set until a clearing write. A hardware set in the same cycle as a clearing write survives the clear.
- R10: A write to the end-of-interrupt slot (0x0B0) pulses `eoi_pulse` high for exactly one cycle. It stores nothing. A read of that slot returns zero with no error response.
- R11: An access to an unmapped offset has three effects. A read returns zero. A write changes no register. `bad_addr` is high for exactly one cycle.
- R12: After reset the registers hold the following values:
  - ID = 0
  - task priority = 0
  - logical destination = 0
  - destination format = 0xFFFF_FFFF
  - spurious vector = 0x0000_00FF
  - error status = 0
  - every vector-table entry = 0x0001_0000
  - `sw_enable`, `eoi_pulse` and `bad_addr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (12) | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| hw_err_set | input | ERR_W (8) | Sticky error-bit set requests from hardware |
| rd_data | output | 32 | Registered read data; holds its value between reads |
| bad_addr | output | 1 | One-cycle error response for an unmapped offset |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt strobe |
| sw_enable | output | 1 | Software-enable flag from spurious-vector bit 8 |

## Verification
Every result of an access sampled at a rising edge is registered by that same edge. This covers `rd_data`, `bad_addr`, `eoi_pulse`, `sw_enable` and every stored register. A read issued in the next access therefore already sees the new value. A hardware error set lands on the edge that samples it.

The bench drives inputs just after a falling edge and samples exactly one rising edge later, at the following falling edge. Back-to-back accesses therefore check each result in its due cycle. A further idle cycle is sampled to confirm that `eoi_pulse` and `bad_addr` have dropped.

// File: rtl/lic_pkg.sv
package lic_pkg;

    localparam int DATA_W   = 32;
    localparam int LVT_N    = 6;
    localparam int LVT_IW   = $clog2(LVT_N);
    localparam int OFF_ID   = 'h020;
    localparam int OFF_VER  = 'h030;
    localparam int OFF_TPR  = 'h080;
    localparam int OFF_EOI  = 'h0B0;
    localparam int OFF_LDR  = 'h0D0;
    localparam int OFF_DFR  = 'h0E0;
    localparam int OFF_SVR  = 'h0F0;
    localparam int OFF_ESR  = 'h280;
    localparam int OFF_LVT  = 'h320;
    localparam int SLOT_STEP = 16;

    typedef enum logic [3:0] {
        SLOT_NONE,
        SLOT_ID,
        SLOT_VER,
        SLOT_TPR,
        SLOT_EOI,
        SLOT_LDR,
        SLOT_DFR,
        SLOT_SVR,
        SLOT_ESR,
        SLOT_LVT
    } slot_e;

    typedef enum logic {
        ERR_IDLE,
        ERR_ARMED
    } err_state_e;

endpackage

// File: rtl/lic_addr_decode.sv
module lic_addr_decode
    import lic_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output slot_e             slot,
    output logic [LVT_IW-1:0] lvt_idx
);

    logic [ADDR_W-1:0] aligned;

    always_comb begin
        aligned = addr & ~ADDR_W'(7);
        slot    = SLOT_NONE;
        lvt_idx = '0;
        unique case (aligned)
            ADDR_W'(OFF_ID):  slot = SLOT_ID;
            ADDR_W'(OFF_VER): slot = SLOT_VER;
            ADDR_W'(OFF_TPR): slot = SLOT_TPR;
            ADDR_W'(OFF_EOI): slot = SLOT_EOI;
            ADDR_W'(OFF_LDR): slot = SLOT_LDR;
            ADDR_W'(OFF_DFR): slot = SLOT_DFR;
            ADDR_W'(OFF_SVR): slot = SLOT_SVR;
            ADDR_W'(OFF_ESR): slot = SLOT_ESR;
            default:          slot = SLOT_NONE;
        endcase
        for (int k = 0; k < LVT_N; k++) begin
            if (aligned == ADDR_W'(OFF_LVT + SLOT_STEP * k)) begin
                slot    = SLOT_LVT;
                lvt_idx = LVT_IW'(k);
            end
        end
    end

endmodule

// File: rtl/lic_err_status.sv
module lic_err_status
    import lic_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [ERR_W-1:0]  hw_set,
    output logic [DATA_W-1:0] esr_q
);

    err_state_e state_q, state_d;
    logic       clear_now;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ERR_IDLE;
        else        state_q <= state_d;
    end

    // Next state and clear decision
    always_comb begin
        state_d   = state_q;
        clear_now = 1'b0;
        unique case (state_q)
            ERR_IDLE: begin
                if (wr_hit) state_d = ERR_ARMED;
            end
            ERR_ARMED: begin
                if (wr_hit) begin
                    state_d   = ERR_IDLE;
                    clear_now = 1'b1;
                end else if (rd_hit) begin
                    state_d = ERR_IDLE;
                end
            end
            default: state_d = ERR_IDLE;
        endcase
    end

    // Stored value: clear first, then accumulate hardware sets
    always_ff @(posedge clk) begin
        if (!rst_n) esr_q <= '0;
        else        esr_q <= (clear_now ? '0 : esr_q) | DATA_W'(hw_set);
    end

    p_arm_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && state_q == ERR_IDLE) |=>
            (state_q == ERR_ARMED && esr_q == ($past(esr_q) | DATA_W'($past(hw_set)))));

    p_second_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && state_q == ERR_ARMED) |=>
            (state_q == ERR_IDLE && esr_q == DATA_W'($past(hw_set))));

    p_read_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !wr_hit) |=> state_q == ERR_IDLE);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && state_q == ERR_ARMED) |=> ((esr_q & $past(esr_q)) == $past(esr_q)));

endmodule

// File: rtl/lic_lvt_bank.sv
module lic_lvt_bank
    import lic_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_VAL  = 32'h0001_0000,
    parameter logic [DATA_W-1:0] KEEP_MSK = 32'h0000_5000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [LVT_IW-1:0]            idx,
    input  logic [DATA_W-1:0]            wdata,
    output logic [LVT_N-1:0][DATA_W-1:0] entry_q
);

    for (genvar k = 0; k < LVT_N; k++) begin : g_entry
        logic hit;
        assign hit = wr_en && (idx == LVT_IW'(k));

        always_ff @(posedge clk) begin
            if (!rst_n)   entry_q[k] <= RST_VAL;
            else if (hit) entry_q[k] <= (wdata & ~KEEP_MSK) | (entry_q[k] & KEEP_MSK);
        end

        p_status_bits_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> ((entry_q[k] & KEEP_MSK) == ($past(entry_q[k]) & KEEP_MSK)));
    end

endmodule

// File: rtl/lic_regbank.sv
module lic_regbank
    import lic_pkg::*;
#(
    parameter int                ADDR_W      = 12,
    parameter int                ERR_W       = 8,
    parameter logic [DATA_W-1:0] VERSION_VAL = 32'h0005_0014
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [ERR_W-1:0]  hw_err_set,
    output logic [DATA_W-1:0] rd_data,
    output logic              bad_addr,
    output logic              eoi_pulse,
    output logic              sw_enable
);

    localparam logic [DATA_W-1:0] LOW8_MSK = 32'h0000_00FF;
    localparam logic [DATA_W-1:0] LDR_MSK  = 32'hFF00_0000;
    localparam logic [DATA_W-1:0] DFR_ONES = 32'h0FFF_FFFF;
    localparam logic [DATA_W-1:0] SVR_RST  = 32'h0000_00FF;
    localparam int                SWEN_BIT = 8;

    slot_e                         slot;
    logic [LVT_IW-1:0]             lvt_idx;
    logic                          wr_hit, rd_hit;
    logic [DATA_W-1:0]             id_q, tpr_q, ldr_q, dfr_q, svr_q, esr_q;
    logic [LVT_N-1:0][DATA_W-1:0]  lvt_q;
    logic [DATA_W-1:0]             lvt_rd, rd_mux;

    assign wr_hit = acc_en && acc_wr;
    assign rd_hit = acc_en && !acc_wr;

    lic_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr    (acc_addr),
        .slot    (slot),
        .lvt_idx (lvt_idx)
    );

    lic_err_status #(.ERR_W(ERR_W)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit && slot == SLOT_ESR),
        .rd_hit (rd_hit && slot == SLOT_ESR),
        .hw_set (hw_err_set),
        .esr_q  (esr_q)
    );

    lic_lvt_bank u_lvt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_hit && slot == SLOT_LVT),
        .idx     (lvt_idx),
        .wdata   (acc_wdata),
        .entry_q (lvt_q)
    );

    // Plain registers with per-slot write rules
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q      <= '0;
            tpr_q     <= '0;
            ldr_q     <= '0;
            dfr_q     <= '1;
            svr_q     <= SVR_RST;
            sw_enable <= 1'b0;
        end else if (wr_hit) begin
            unique case (slot)
                SLOT_ID:  id_q  <= acc_wdata & LOW8_MSK;
                SLOT_TPR: tpr_q <= acc_wdata & LOW8_MSK;
                SLOT_LDR: ldr_q <= acc_wdata & LDR_MSK;
                SLOT_DFR: dfr_q <= acc_wdata | DFR_ONES;
                SLOT_SVR: begin
                    svr_q     <= acc_wdata;
                    sw_enable <= acc_wdata[SWEN_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        lvt_rd = '0;
        for (int k = 0; k < LVT_N; k++) begin
            if (lvt_idx == LVT_IW'(k)) lvt_rd = lvt_q[k];
        end
    end

    always_comb begin
        unique case (slot)
            SLOT_ID:  rd_mux = id_q;
            SLOT_VER: rd_mux = VERSION_VAL;
            SLOT_TPR: rd_mux = tpr_q;
            SLOT_LDR: rd_mux = ldr_q;
            SLOT_DFR: rd_mux = dfr_q;
            SLOT_SVR: rd_mux = svr_q;
            SLOT_ESR: rd_mux = esr_q;
            SLOT_LVT: rd_mux = lvt_rd;
            default:  rd_mux = '0;
        endcase
    end

    // Port-side outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            bad_addr  <= 1'b0;
            eoi_pulse <= 1'b0;
        end else begin
            if (rd_hit) rd_data <= rd_mux;
            bad_addr  <= acc_en && slot == SLOT_NONE;
            eoi_pulse <= wr_hit && slot == SLOT_EOI;
        end
    end

    p_eoi_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && slot == SLOT_EOI) |=> (eoi_pulse && !bad_addr));

    p_unmapped_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && slot == SLOT_NONE) |=> (bad_addr && rd_data == '0));

    p_unmapped_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && slot == SLOT_NONE) |=>
            ($stable(id_q) && $stable(tpr_q) && $stable(svr_q) && $stable(lvt_q) && bad_addr));

    p_swen_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && slot == SLOT_SVR) |=> sw_enable == $past(acc_wdata[SWEN_BIT]));

endmodule

// File: tb/test_lic_regbank.sv
module test_lic_regbank;

    localparam logic [31:0] VER = 32'h0005_0014;
    localparam int NV = 24;
    // {wr, expect_bad, addr[11:0], wdata[31:0], expect[31:0]}
    localparam logic [77:0] VEC [NV] = '{
        {1'b1, 1'b0, 12'h020, 32'hDEAD_BEEF, 32'h0},
        {1'b0, 1'b0, 12'h020, 32'h0,         32'h0000_00EF},
        {1'b0, 1'b0, 12'h024, 32'h0,         32'h0000_00EF},
        {1'b1, 1'b0, 12'h080, 32'h1234_5678, 32'h0},
        {1'b0, 1'b0, 12'h080, 32'h0,         32'h0000_0078},
        {1'b1, 1'b0, 12'h030, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 1'b0, 12'h030, 32'h0,         VER},
        {1'b1, 1'b0, 12'h0D0, 32'hABCD_EF12, 32'h0},
        {1'b0, 1'b0, 12'h0D0, 32'h0,         32'hAB00_0000},
        {1'b1, 1'b0, 12'h0E0, 32'h5000_0000, 32'h0},
        {1'b0, 1'b0, 12'h0E0, 32'h0,         32'h5FFF_FFFF},
        {1'b1, 1'b0, 12'h320, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 1'b0, 12'h320, 32'h0,         32'hFFFF_AFFF},
        {1'b1, 1'b0, 12'h370, 32'h0000_00AA, 32'h0},
        {1'b0, 1'b0, 12'h374, 32'h0,         32'h0000_00AA},
        {1'b1, 1'b0, 12'h340, 32'h0000_1234, 32'h0},
        {1'b0, 1'b0, 12'h340, 32'h0,         32'h0000_0234},
        {1'b0, 1'b1, 12'h36C, 32'h0,         32'h0},
        {1'b0, 1'b1, 12'h328, 32'h0,         32'h0},
        {1'b0, 1'b1, 12'h028, 32'h0,         32'h0},
        {1'b1, 1'b1, 12'h400, 32'hFFFF_FFFF, 32'h0},
        {1'b1, 1'b1, 12'h02C, 32'h0000_0011, 32'h0},
        {1'b0, 1'b0, 12'h020, 32'h0,         32'h0000_00EF},
        {1'b0, 1'b0, 12'h0B0, 32'h0,         32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [7:0]  hw_err_set = '0;
    logic [31:0] rd_data;
    logic        bad_addr, eoi_pulse, sw_enable;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lic_regbank i_lic_regbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (acc_en),
        .acc_wr     (acc_wr),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .hw_err_set (hw_err_set),
        .rd_data    (rd_data),
        .bad_addr   (bad_addr),
        .eoi_pulse  (eoi_pulse),
        .sw_enable  (sw_enable)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with results sampled.
    task automatic access(input logic wr, input logic [11:0] addr, input logic [31:0] wd);
        acc_en = 1'b1; acc_wr = wr; acc_addr = addr; acc_wdata = wd;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] addr, input logic [31:0] exp);
        access(1'b0, addr, 32'h0);
        check(req, rd_data, exp);
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        check("R12 sw_enable", {31'b0, sw_enable}, 32'h0);
        check("R12 eoi_pulse", {31'b0, eoi_pulse}, 32'h0);
        check("R12 bad_addr",  {31'b0, bad_addr},  32'h0);
        rd_check("R12 id",  12'h020, 32'h0);
        rd_check("R12 tpr", 12'h080, 32'h0);
        rd_check("R12 ldr", 12'h0D0, 32'h0);
        rd_check("R12 dfr", 12'h0E0, 32'hFFFF_FFFF);
        rd_check("R12 svr", 12'h0F0, 32'h0000_00FF);
        rd_check("R12 esr", 12'h280, 32'h0);
        for (int k = 0; k < 6; k++) rd_check("R12 lvt", 12'h320 + 12'(16 * k), 32'h0001_0000);

        // Vector table: R1 R2 R3 R4 R5 R10 R11
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][77], VEC[i][75:64], VEC[i][63:32]);
            check("R11 bad_addr vec", {31'b0, bad_addr}, {31'b0, VEC[i][76]});
            if (!VEC[i][77]) check("R1/R2/R3/R4/R5 rd vec", rd_data, VEC[i][31:0]);
        end
        idle();
        check("R11 bad_addr one cycle", {31'b0, bad_addr}, 32'h0);

        // R6 software enable
        access(1'b1, 12'h0F0, 32'h0000_01FF);
        check("R6 sw_enable set", {31'b0, sw_enable}, 32'h1);
        rd_check("R6 svr readback", 12'h0F0, 32'h0000_01FF);
        access(1'b1, 12'h0F4, 32'h0000_00EF);
        check("R6 sw_enable clear", {31'b0, sw_enable}, 32'h0);

        // R10 end-of-interrupt strobe
        access(1'b1, 12'h0B0, 32'hFFFF_FFFF);
        check("R10 eoi high", {31'b0, eoi_pulse}, 32'h1);
        check("R10 eoi no bad", {31'b0, bad_addr}, 32'h0);
        idle();
        check("R10 eoi one cycle", {31'b0, eoi_pulse}, 32'h0);
        rd_check("R10 eoi reads zero", 12'h0B0, 32'h0);

        // R9 sticky hardware sets
        hw_err_set = 8'h04; idle(); hw_err_set = 8'h00;
        rd_check("R9 hw set", 12'h280, 32'h0000_0004);
        hw_err_set = 8'h40; idle(); hw_err_set = 8'h00;
        rd_check("R9 accumulate", 12'h280, 32'h0000_0044);

        // R7 arm then clear
        access(1'b1, 12'h280, 32'h0);
        access(1'b1, 12'h280, 32'h0);
        rd_check("R7 two writes clear", 12'h280, 32'h0);
        hw_err_set = 8'h04; idle(); hw_err_set = 8'h00;
        access(1'b1, 12'h280, 32'h0);
        rd_check("R7 arm keeps value", 12'h280, 32'h0000_0004);
        // R8 read disarmed: next write only arms
        access(1'b1, 12'h280, 32'h0);
        rd_check("R8 read disarms", 12'h280, 32'h0000_0004);
        // R9 set during clearing write survives
        access(1'b1, 12'h280, 32'h0);
        hw_err_set = 8'h02;
        access(1'b1, 12'h280, 32'h0);
        hw_err_set = 8'h00;
        rd_check("R9 set beats clear", 12'h280, 32'h0000_0002);

        done = 1'b1;
        finish_run();
    end

endmodule